// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a loaded number of seconds and raises an alarm when the count runs out. Software works out how many seconds remain until the wanted moment and writes that figure into the load register. While counting is enabled, each one-second strobe takes one off the remaining count. When the count steps from one to zero, a sticky pending flag is set and the counter stays at zero.

The pending flag drives two outputs, each through its own enable. One is an interrupt line and the other is a wakeup line. Software clears the flag by writing a one to its bit. A simple register port carries the data: a single-cycle write strobe with an address and data, and a combinational read path selected by a read address. No data stream passes through the block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `alarm_cd_top`

## Requirements
- R1: After reset the remaining count, the load value, all three enables and the pending flag are zero, and `irq_o` and `wake_o` are low.
- R2: A write to offset 0x20 sets both the remaining count and the load value. Reading 0x20 returns the load value, and reading 0x24 returns the remaining count. Writing 0 to 0x20 stops a countdown in progress: no pending flag follows from it.
- R3: While bit 0 of offset 0x28 (the count enable) is 0, strobes on `tick_i` leave the remaining count unchanged.
- R4: While counting is enabled, each cycle with `tick_i` high lowers a non-zero count by exactly one. Cycles without `tick_i` leave the count unchanged.
- R5: A step of the count from 1 to 0 sets the pending flag, which reads as bit 0 of offset 0x30. Further strobes keep the count at 0 and do not disturb the flag.
- R6: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 to that bit has no effect.
- R7: If an expiry and a write-1 clear land in the same cycle, the pending flag ends up set.
- R8: `irq_o` is high exactly when the pending flag is set and bit 0 of offset 0x2C (the interrupt enable) is 1.
- R9: `wake_o` is high exactly when the pending flag is set and bit 0 of offset 0x50 (the wakeup enable) is 1. This does not depend on the interrupt enable.
- R10: A write to 0x20 in the same cycle as a counting strobe loads the written value, and no decrement is applied.
- R11: The three enable registers read back their bit 0 with all other bits zero. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Interrupt, pending gated by interrupt enable |
| wake_o | output | 1 | Wakeup, pending gated by wakeup enable |

## Verification
The properties assume that `tick_i` is a synchronous strobe whose value is known in every cycle after reset. They also assume that a write carries known address and data whenever `wr_en_i` is high. The stimulus holds `tick_i` high for only one clock at a time and changes all inputs on the falling edge. Each write lasts exactly one cycle. The two same-cycle collisions, an expiry against a clear and a load against a strobe, are driven deliberately so that the priority rules are exercised.

// File: rtl/alarm_cd_pkg.sv
package alarm_cd_pkg;
  // Byte offsets decoded by software; kept fixed.
  localparam int OFF_LOAD  = 'h20;
  localparam int OFF_COUNT = 'h24;
  localparam int OFF_CEN   = 'h28;
  localparam int OFF_IEN   = 'h2C;
  localparam int OFF_PEND  = 'h30;
  localparam int OFF_WEN   = 'h50;

  typedef struct packed {
    logic cnt_en;
    logic irq_en;
    logic wake_en;
  } alarm_enables_t;
endpackage

// File: rtl/alarm_cd_regs.sv
module alarm_cd_regs
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pend_i,
  output alarm_enables_t    en_o,
  output logic              load_wr_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_wr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CEN   = ADDR_W'(OFF_CEN);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_WEN   = ADDR_W'(OFF_WEN);

  alarm_enables_t    en_q;
  logic [CNT_W-1:0]  load_q;

  assign load_wr_o  = wr_en_i && (wr_addr_i == A_LOAD);
  assign load_val_o = wr_data_i[CNT_W-1:0];
  // Write-one-to-clear strobe for the pending flag.
  assign clr_wr_o   = wr_en_i && (wr_addr_i == A_PEND) && wr_data_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      load_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_LOAD) load_q        <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == A_CEN)  en_q.cnt_en  <= wr_data_i[0];
      if (wr_addr_i == A_IEN)  en_q.irq_en  <= wr_data_i[0];
      if (wr_addr_i == A_WEN)  en_q.wake_en <= wr_data_i[0];
    end
  end

  assign en_o = en_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_LOAD:  rd_data_o = DATA_W'(load_q);
      A_COUNT: rd_data_o = DATA_W'(count_i);
      A_CEN:   rd_data_o = DATA_W'(en_q.cnt_en);
      A_IEN:   rd_data_o = DATA_W'(en_q.irq_en);
      A_PEND:  rd_data_o = DATA_W'(pend_i);
      A_WEN:   rd_data_o = DATA_W'(en_q.wake_en);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/alarm_cd_counter.sv
module alarm_cd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_en_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             step;

  // A load overrides a strobe in the same cycle.
  assign step     = tick_i && cnt_en_i && !load_wr_i && (count_q != '0);
  assign expire_o = step && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)         count_q <= '0;
    else if (load_wr_i) count_q <= load_val_i;
    else if (step)      count_q <= count_q - ONE;
  end

  assign count_o = count_q;
endmodule

// File: rtl/alarm_cd_pending.sv
module alarm_cd_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_wr_i,
  input  logic irq_en_i,
  input  logic wake_en_i,
  output logic pend_o,
  output logic irq_o,
  output logic wake_o
);
  logic pend_q;

  // Expiry has priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (expire_i) pend_q <= 1'b1;
    else if (clr_wr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & irq_en_i;
  assign wake_o = pend_q & wake_en_i;
endmodule

// File: rtl/alarm_cd_top.sv
module alarm_cd_top
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);
  alarm_enables_t   en_w;
  logic             load_wr_w;
  logic [CNT_W-1:0] load_val_w;
  logic             clr_wr_w;
  logic [CNT_W-1:0] count_w;
  logic             expire_w;
  logic             pend_w;

  alarm_cd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .count_i(count_w), .pend_i(pend_w),
    .en_o(en_w), .load_wr_o(load_wr_w), .load_val_o(load_val_w),
    .clr_wr_o(clr_wr_w), .rd_data_o(rd_data_o)
  );

  alarm_cd_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_en_i(en_w.cnt_en),
    .load_wr_i(load_wr_w), .load_val_i(load_val_w),
    .count_o(count_w), .expire_o(expire_w)
  );

  alarm_cd_pending pend_i (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_w), .clr_wr_i(clr_wr_w),
    .irq_en_i(en_w.irq_en), .wake_en_i(en_w.wake_en),
    .pend_o(pend_w), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/alarm_cd_chk.sv
module alarm_cd_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_en,
  input logic             irq_en,
  input logic             wake_en,
  input logic             load_wr,
  input logic [CNT_W-1:0] load_val,
  input logic             clr_wr,
  input logic [CNT_W-1:0] count,
  input logic             pend,
  input logic             irq,
  input logic             wake
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && !(tick && cnt_en)) |=> $stable(count)); // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && tick && cnt_en && count != '0) |=> count == $past(count) - CNT_W'(1)); // R4
  AST_EXPIRY_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && tick && cnt_en && count == CNT_W'(1)) |=> (pend && count == '0)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(!load_wr && tick && cnt_en && count == CNT_W'(1))) |=> !pend); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_wr) |=> pend); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count == $past(load_val)); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || !pend) |-> !irq); // R8
  AST_WAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en || !pend) |-> !wake); // R9
endmodule

bind alarm_cd_top alarm_cd_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_i),
  .cnt_en(en_w.cnt_en), .irq_en(en_w.irq_en), .wake_en(en_w.wake_en),
  .load_wr(load_wr_w), .load_val(load_val_w), .clr_wr(clr_wr_w),
  .count(count_w), .pend(pend_w), .irq(irq_o), .wake(wake_o)
);

// File: tb/alarm_cd_top_tb_top.sv
module alarm_cd_top_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_OUT = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;   // write data or expected read/out value
    logic [3:0]  req;    // requirement number for messages
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,  8'h28, 32'd1, 4'd3},  // enable counting R3
    '{OP_WR,  8'h20, 32'd3, 4'd2},  // load 3 R2
    '{OP_RD,  8'h24, 32'd3, 4'd2},
    '{OP_RD,  8'h20, 32'd3, 4'd2},
    '{OP_TK,  8'h00, 32'd0, 4'd4},
    '{OP_RD,  8'h24, 32'd2, 4'd4},  // R4
    '{OP_TK,  8'h00, 32'd0, 4'd4},
    '{OP_RD,  8'h24, 32'd1, 4'd4},
    '{OP_RD,  8'h30, 32'd0, 4'd5},
    '{OP_TK,  8'h00, 32'd0, 4'd5},
    '{OP_RD,  8'h24, 32'd0, 4'd5},  // R5
    '{OP_RD,  8'h30, 32'd1, 4'd5},
    '{OP_OUT, 8'h00, 32'd0, 4'd8},  // enables off R8
    '{OP_WR,  8'h2C, 32'd1, 4'd8},
    '{OP_OUT, 8'h00, 32'd1, 4'd8},
    '{OP_WR,  8'h50, 32'd1, 4'd9},
    '{OP_OUT, 8'h00, 32'd3, 4'd9},  // R9
    '{OP_TK,  8'h00, 32'd0, 4'd5},
    '{OP_RD,  8'h24, 32'd0, 4'd5},
    '{OP_RD,  8'h30, 32'd1, 4'd5},
    '{OP_WR,  8'h30, 32'd0, 4'd6},  // write 0: no effect R6
    '{OP_RD,  8'h30, 32'd1, 4'd6},
    '{OP_WR,  8'h30, 32'd1, 4'd6},
    '{OP_RD,  8'h30, 32'd0, 4'd6},
    '{OP_OUT, 8'h00, 32'd0, 4'd8},
    '{OP_WR,  8'h28, 32'd0, 4'd3},
    '{OP_WR,  8'h20, 32'd4, 4'd3},
    '{OP_TK,  8'h00, 32'd0, 4'd3},
    '{OP_RD,  8'h24, 32'd4, 4'd3},  // disabled: unchanged R3
    '{OP_WR,  8'h28, 32'd1, 4'd4},
    '{OP_TK,  8'h00, 32'd0, 4'd4},
    '{OP_RD,  8'h24, 32'd3, 4'd4},
    '{OP_WR,  8'h20, 32'd0, 4'd2},  // abort via zero load R2
    '{OP_RD,  8'h24, 32'd0, 4'd2},
    '{OP_TK,  8'h00, 32'd0, 4'd2},
    '{OP_RD,  8'h24, 32'd0, 4'd2},
    '{OP_RD,  8'h30, 32'd0, 4'd2},
    '{OP_RD,  8'h28, 32'd1, 4'd11}, // R11
    '{OP_RD,  8'h40, 32'd0, 4'd11},
    '{OP_RD,  8'h2C, 32'd1, 4'd11}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              irq_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_cd_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock cycle with optional write and optional strobe.
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; tick_i = tk;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr_i = a;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic out_check(input string req, input logic [1:0] exp);
    #1;
    check(req, {30'd0, wake_o, irq_o}, {30'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_check("R1", 8'h20, 0);
    rd_check("R1", 8'h24, 0);
    rd_check("R1", 8'h28, 0);
    rd_check("R1", 8'h2C, 0);
    rd_check("R1", 8'h30, 0);
    rd_check("R1", 8'h50, 0);
    out_check("R1", 2'b00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      case (VECS[i].op)
        OP_WR:   cycle(1'b1, VECS[i].addr, VECS[i].data, 1'b0);
        OP_TK:   cycle(1'b0, 8'h00, 32'd0, 1'b1);
        OP_RD:   rd_check(tag, VECS[i].addr, VECS[i].data);
        default: out_check(tag, VECS[i].data[1:0]);
      endcase
    end

    // R7: expiry and write-1 clear in the same cycle
    cycle(1'b1, 8'h20, 32'd1, 1'b0);
    cycle(1'b1, 8'h30, 32'd1, 1'b1);
    rd_check("R7", 8'h30, 1);
    rd_check("R7", 8'h24, 0);

    // R9: wakeup without interrupt enable
    cycle(1'b1, 8'h2C, 32'd0, 1'b0);
    out_check("R9", 2'b10);

    // R10: load beats a same-cycle strobe
    cycle(1'b1, 8'h20, 32'd7, 1'b1);
    rd_check("R10", 8'h24, 7);
    // R4: no strobe, no change
    repeat (5) @(negedge clk);
    rd_check("R4", 8'h24, 7);

    // R1: reset again from a busy state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_check("R1", 8'h24, 0);
    rd_check("R1", 8'h30, 0);
    rd_check("R1", 8'h50, 0);
    out_check("R1", 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule